// File: doc/BRIEF.md
# Host Power State Sequencer

This block walks a host processor through its platform power states: mechanical off, soft off, suspend-to-RAM, working, and an optional low-power idle state that the working state reaches without removing power. The block is a synchronous state machine. It watches the two power-good rails, the host's three active-low sleep outputs and a flag that tells it the host means to suspend. From these it drives the main rail enable, a power-button request toward the host, a wireless mode code, a flag that allows deep sleep, and one-cycle event pulses that other logic subscribes to.

Every move between two stable states goes through a one-cycle transitional state. The pulses and the mode updates are tied to those transitional states. If the soft-off power-good is lost, any powered state falls to the off path. From mechanical off, a power-on request raises the rail. The machine then waits a bounded number of cycles for power-good before it gives up. A forced-shutdown request presses the host's power button until the machine reaches soft off. All level inputs pass through a two-flop synchronizer before the machine sees them.

Top module: `host_power_sequencer`

## Requirements
- R1: While reset is high, the starting state is chosen from the synchronized power-good inputs. If the working-state good is high, the start is working: rail_en=1, radio_mode=2, deep_sleep_ok=0. Otherwise, if the soft-off good is high, the start is soft off: rail_en=1, radio_mode=0, deep_sleep_ok=1. Otherwise the start is mechanical off: rail_en=0, radio_mode=0, deep_sleep_ok=1.
- R2: In mechanical off, power_on_req raises rail_en and starts a wait for s5_pgood. If s5_pgood arrives during the wait, the machine settles in soft off with the rail still high and emits no event.
- R3: If s5_pgood does not arrive, rail_en stays high for exactly TIMEOUT_CYCLES clock cycles, then falls and the machine returns to mechanical off.
- R4: In soft off, host_slp5_n high produces one evt_startup pulse, and the machine then rests in suspend-to-RAM.
- R5: In suspend-to-RAM, the next state is chosen in this priority order: loss of s5_pgood (to the off path), then host_slp3_n high (to working), then host_slp5_n low (to soft off).
- R6: Suspend-to-RAM to working emits evt_resume in the third clock edge after host_slp3_n rises. One edge later radio_mode is 2 (on) and deep_sleep_ok is 0.
- R7: Working to suspend-to-RAM (host_slp3_n low, no idle entry) emits evt_suspend and sets radio_mode to 1 (suspended) and deep_sleep_ok to 1.
- R8: Suspend-to-RAM to soft off emits evt_shutdown and sets radio_mode to 0 (off).
- R9: Loss of s5_pgood in soft off, suspend-to-RAM, working or low-power idle ends in mechanical off with rail_en=0. Idle reaches that point by passing through working.
- R10: Working enters low-power idle only when idle_intent is high and host_slp0_n is low. The entry sets deep_sleep_ok and emits no event pulse.
- R11: Low-power idle returns to working only when host_slp0_n and host_slp3_n are both high. The return clears deep_sleep_ok and emits no event pulse.
- R12: force_off_req raises host_button only in a powered or powering state, that is, not in mechanical off, soft off or the transitions into them. host_button falls, and the request is dropped, once the machine is in soft off.
- R13: Each event output is high for one cycle at a time, and at most one event output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the starting state |
| s5_pgood | input | 1 | Soft-off rail power-good (asynchronous) |
| s0_pgood | input | 1 | Working rail power-good (asynchronous) |
| host_slp5_n | input | 1 | Host soft-off request, active low |
| host_slp3_n | input | 1 | Host suspend-to-RAM request, active low |
| host_slp0_n | input | 1 | Host low-power idle request, active low |
| idle_intent | input | 1 | Host has declared it intends to suspend to idle |
| force_off_req | input | 1 | Request to force the host off through its power button |
| power_on_req | input | 1 | Request to leave mechanical off |
| rail_en | output | 1 | Main rail enable |
| host_button | output | 1 | Power-button drive toward the host, high = pressed |
| radio_mode | output | 2 | Wireless mode: 0 off, 1 suspended, 2 on |
| deep_sleep_ok | output | 1 | Local deep sleep is allowed |
| evt_startup | output | 1 | One-cycle pulse on soft off to suspend-to-RAM |
| evt_resume | output | 1 | One-cycle pulse on suspend-to-RAM to working |
| evt_suspend | output | 1 | One-cycle pulse on working to suspend-to-RAM |
| evt_shutdown | output | 1 | One-cycle pulse on suspend-to-RAM to soft off |

## Verification
The assertions take for granted that each input level is held for at least the synchronizer depth plus one cycle. They also assume the power-good inputs are stable while reset is high, so that the starting state is chosen from settled values. The bench changes one input at a time, or two at once only where a priority is under test, and holds each level for many cycles. This keeps every transitional state to one cycle and every event pulse isolated. The reset-start cases are run by presetting the power-good inputs and then holding reset for five cycles, which is longer than the synchronizer needs.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [3:0] {
        PS_G3     = 4'd0,
        PS_G3_S5  = 4'd1,
        PS_S5     = 4'd2,
        PS_S5_S3  = 4'd3,
        PS_S3     = 4'd4,
        PS_S3_S0  = 4'd5,
        PS_S0     = 4'd6,
        PS_S0_S3  = 4'd7,
        PS_S3_S5  = 4'd8,
        PS_S5_G3  = 4'd9,
        PS_S0_IDL = 4'd10,
        PS_IDL    = 4'd11,
        PS_IDL_S0 = 4'd12
    } pstate_e;

    typedef enum logic [1:0] {
        RADIO_OFF  = 2'd0,
        RADIO_SUSP = 2'd1,
        RADIO_ON   = 2'd2
    } radio_e;

    // Synchronized view of the level inputs
    typedef struct packed {
        logic s5_pg;
        logic s0_pg;
        logic slp5_n;
        logic slp3_n;
        logic slp0_n;
        logic intent;
        logic force_off;
        logic power_on;
    } hostin_t;

    typedef struct packed {
        logic startup;
        logic resume;
        logic suspend;
        logic shutdown;
    } evt_t;

    // Starting state chosen from the power-good levels present in reset
    function automatic pstate_e boot_state(input logic s5_pg, input logic s0_pg);
        if (s0_pg)      return PS_S0;
        else if (s5_pg) return PS_S5;
        else            return PS_G3;
    endfunction

    // States counted as "off or on the way to off"
    function automatic logic is_off_state(input pstate_e s);
        return (s == PS_G3) || (s == PS_G3_S5) || (s == PS_S5) ||
               (s == PS_S5_G3) || (s == PS_S3_S5);
    endfunction

    // Rail enable that goes with a given state
    function automatic logic rail_on_in(input pstate_e s);
        return (s != PS_G3) && (s != PS_S5_G3);
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
module pwrseq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Plain data pipe; no reset so the starting state can be sampled in reset
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) pipe[g] <= d;
        end else begin : g_rest
            always_ff @(posedge clk) pipe[g] <= pipe[g-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt_q <= '0;
        else if (cnt_q != LAST)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R3
    cnt_never_over_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST)
        else $error("wait counter beyond limit");

    // R3
    cnt_clears_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (cnt_q == '0))
        else $error("wait counter not cleared outside wait");
endmodule

// File: rtl/pwrseq_fsm.sv
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter bit IDLE_EN = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  hostin_t in_s,
    input  logic    wait_expired,
    output pstate_e state,
    output logic    rail_en,
    output logic    button,
    output radio_e  radio,
    output logic    deep_ok,
    output evt_t    evt
);
    pstate_e st_q, st_d;
    logic    rail_q, btn_q, deep_q;
    radio_e  radio_q;
    logic    idle_entry;

    if (IDLE_EN) begin : g_idle
        assign idle_entry = in_s.intent && !in_s.slp0_n;
    end else begin : g_no_idle
        assign idle_entry = 1'b0;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PS_G3:     if (in_s.power_on) st_d = PS_G3_S5;
            PS_G3_S5: begin
                if (in_s.s5_pg)        st_d = PS_S5;
                else if (wait_expired) st_d = PS_G3;
            end
            PS_S5: begin
                if (!in_s.s5_pg)     st_d = PS_S5_G3;
                else if (in_s.slp5_n) st_d = PS_S5_S3;
            end
            PS_S5_S3:  st_d = in_s.s5_pg ? PS_S3 : PS_S5_G3;
            PS_S3: begin
                if (!in_s.s5_pg)      st_d = PS_S5_G3;
                else if (in_s.slp3_n)  st_d = PS_S3_S0;
                else if (!in_s.slp5_n) st_d = PS_S3_S5;
            end
            PS_S3_S0:  st_d = in_s.s5_pg ? PS_S0 : PS_S5_G3;
            PS_S0: begin
                if (!in_s.s5_pg)      st_d = PS_S5_G3;
                else if (idle_entry)   st_d = PS_S0_IDL;
                else if (!in_s.slp3_n) st_d = PS_S0_S3;
            end
            PS_S0_S3:  st_d = PS_S3;
            PS_S3_S5:  st_d = PS_S5;
            PS_S5_G3:  st_d = PS_G3;
            PS_S0_IDL: st_d = PS_IDL;
            PS_IDL: begin
                if (in_s.slp0_n && in_s.slp3_n) st_d = PS_IDL_S0;
                else if (!in_s.s5_pg)          st_d = PS_S0;
            end
            PS_IDL_S0: st_d = PS_S0;
            default:   st_d = PS_G3;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= boot_state(in_s.s5_pg, in_s.s0_pg);
            rail_q  <= rail_on_in(boot_state(in_s.s5_pg, in_s.s0_pg));
            radio_q <= in_s.s0_pg ? RADIO_ON : RADIO_OFF;
            deep_q  <= !in_s.s0_pg;
            btn_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            rail_q <= rail_on_in(st_d);
            unique case (st_q)
                PS_S3_S0:  begin radio_q <= RADIO_ON;   deep_q <= 1'b0; end
                PS_S0_S3:  begin radio_q <= RADIO_SUSP; deep_q <= 1'b1; end
                PS_S3_S5:  radio_q <= RADIO_OFF;
                PS_S0_IDL: deep_q <= 1'b1;
                PS_IDL_S0: deep_q <= 1'b0;
                default: ;
            endcase
            if (st_q == PS_S5)
                btn_q <= 1'b0;
            else if (in_s.force_off && !is_off_state(st_q))
                btn_q <= 1'b1;
        end
    end

    assign state        = st_q;
    assign rail_en      = rail_q;
    assign button       = btn_q;
    assign radio        = radio_q;
    assign deep_ok      = deep_q;
    assign evt.startup  = (st_q == PS_S5_S3);
    assign evt.resume   = (st_q == PS_S3_S0);
    assign evt.suspend  = (st_q == PS_S0_S3);
    assign evt.shutdown = (st_q == PS_S3_S5);

    // R13
    evt_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt))
        else $error("more than one event pulse");

    // R13
    resume_single_chk: assert property (@(posedge clk) disable iff (rst)
        evt.resume |=> !evt.resume)
        else $error("resume pulse longer than a cycle");

    // R6
    resume_modes_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_S3_S0) && in_s.s5_pg |=> (radio_q == RADIO_ON) && !deep_q)
        else $error("resume did not set radio on / clear deep sleep");

    // R7
    suspend_modes_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_S0_S3) |=> (radio_q == RADIO_SUSP) && deep_q)
        else $error("suspend did not set radio/deep sleep");

    // R10
    idle_deep_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_IDL) |-> deep_q)
        else $error("deep sleep not allowed in idle");

    // R9
    off_path_rail_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_S5_G3) |=> !rail_q && (st_q == PS_G3))
        else $error("off path did not drop the rail");

    // R5
    s3_pg_first_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_S3) && !in_s.s5_pg |=> (st_q == PS_S5_G3))
        else $error("power loss did not win in suspend");

    // R12
    button_release_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_S5) |=> !btn_q)
        else $error("button still pressed after soft off");

    // R12
    button_only_on_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(btn_q) |-> !is_off_state($past(st_q)))
        else $error("button pressed while already off");
endmodule

// File: rtl/host_power_sequencer.sv
module host_power_sequencer
    import pwrseq_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 1000,
    parameter int SYNC_STAGES    = 2,
    parameter bit IDLE_EN        = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       s5_pgood,
    input  logic       s0_pgood,
    input  logic       host_slp5_n,
    input  logic       host_slp3_n,
    input  logic       host_slp0_n,
    input  logic       idle_intent,
    input  logic       force_off_req,
    input  logic       power_on_req,
    output logic       rail_en,
    output logic       host_button,
    output logic [1:0] radio_mode,
    output logic       deep_sleep_ok,
    output logic       evt_startup,
    output logic       evt_resume,
    output logic       evt_suspend,
    output logic       evt_shutdown
);
    localparam int IN_W = $bits(hostin_t);

    hostin_t          raw_in, syn_in;
    logic [IN_W-1:0]  syn_vec;
    pstate_e          state;
    logic             wait_expired;
    radio_e           radio;
    evt_t             evt;

    always_comb begin
        raw_in.s5_pg     = s5_pgood;
        raw_in.s0_pg     = s0_pgood;
        raw_in.slp5_n    = host_slp5_n;
        raw_in.slp3_n    = host_slp3_n;
        raw_in.slp0_n    = host_slp0_n;
        raw_in.intent    = idle_intent;
        raw_in.force_off = force_off_req;
        raw_in.power_on  = power_on_req;
    end

    pwrseq_sync #(.W(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .d   (raw_in),
        .q   (syn_vec)
    );

    assign syn_in = hostin_t'(syn_vec);

    pwrseq_timer #(.LIMIT(TIMEOUT_CYCLES)) u_wait (
        .clk     (clk),
        .rst     (rst),
        .run     (state == PS_G3_S5),
        .expired (wait_expired)
    );

    pwrseq_fsm #(.IDLE_EN(IDLE_EN)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .in_s         (syn_in),
        .wait_expired (wait_expired),
        .state        (state),
        .rail_en      (rail_en),
        .button       (host_button),
        .radio        (radio),
        .deep_ok      (deep_sleep_ok),
        .evt          (evt)
    );

    assign radio_mode   = radio;
    assign evt_startup  = evt.startup;
    assign evt_resume   = evt.resume;
    assign evt_suspend  = evt.suspend;
    assign evt_shutdown = evt.shutdown;
endmodule

// File: tb/host_power_sequencer_tb.sv
module host_power_sequencer_tb;
    localparam int TMO = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic s5_pgood = 0, s0_pgood = 0, slp5_n = 0, slp3_n = 0, slp0_n = 1;
    logic intent = 0, force_off = 0, power_on = 0;
    logic rail_en, host_button, deep_sleep_ok;
    logic [1:0] radio_mode;
    logic ev_st, ev_rs, ev_sp, ev_sd;

    int checks = 0, failures = 0;
    int n_st = 0, n_rs = 0, n_sp = 0, n_sd = 0, n_multi = 0, n_rail = 0;
    logic [3:0] prev_ev = 4'b0;

    always #4 clk = ~clk;  // 125 MHz

    host_power_sequencer #(.TIMEOUT_CYCLES(TMO), .SYNC_STAGES(2), .IDLE_EN(1'b1)) u_dut (
        .clk(clk), .rst(rst), .s5_pgood(s5_pgood), .s0_pgood(s0_pgood),
        .host_slp5_n(slp5_n), .host_slp3_n(slp3_n), .host_slp0_n(slp0_n),
        .idle_intent(intent), .force_off_req(force_off), .power_on_req(power_on),
        .rail_en(rail_en), .host_button(host_button), .radio_mode(radio_mode),
        .deep_sleep_ok(deep_sleep_ok), .evt_startup(ev_st), .evt_resume(ev_rs),
        .evt_suspend(ev_sp), .evt_shutdown(ev_sd)
    );

    // Event and rail observers, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            n_st += int'(ev_st);
            n_rs += int'(ev_rs);
            n_sp += int'(ev_sp);
            n_sd += int'(ev_sd);
            n_rail += int'(rail_en);
            if ((({ev_st, ev_rs, ev_sp, ev_sd} & prev_ev) != 4'b0) ||
                ($countones({ev_st, ev_rs, ev_sp, ev_sd}) > 1))
                n_multi++;
        end
        prev_ev = {ev_st, ev_rs, ev_sp, ev_sd};
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clr();
        @(posedge clk);
        n_st = 0; n_rs = 0; n_sp = 0; n_sd = 0; n_rail = 0;
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        wait_n(5);
        rst = 1'b0;
        wait_n(1);
    endtask

    task automatic pulse_on();
        power_on = 1'b1; wait_n(4); power_on = 1'b0;
    endtask

    task automatic pulse_force();
        force_off = 1'b1; wait_n(4); force_off = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        // R1 mechanical off start
        do_reset();
        chk("R1 g3 rail", int'(rail_en), 0);
        chk("R1 g3 radio", int'(radio_mode), 0);
        chk("R1 g3 deep", int'(deep_sleep_ok), 1);
        chk("R1 g3 button", int'(host_button), 0);

        // R12 force ignored while off
        pulse_force(); wait_n(6);
        chk("R12 force in off", int'(host_button), 0);

        // R3 wait timeout without power-good
        clr(); pulse_on(); wait_n(60);
        chk("R3 rail high cycles", n_rail, TMO);
        chk("R3 rail low after timeout", int'(rail_en), 0);

        // R2 power-on with power-good present
        s5_pgood = 1; wait_n(4);
        clr(); pulse_on(); wait_n(20);
        chk("R2 rail high in soft off", int'(rail_en), 1);
        chk("R2 no events", n_st + n_rs + n_sp + n_sd, 0);

        // R4 startup
        clr(); slp5_n = 1; wait_n(10);
        chk("R4 startup pulses", n_st, 1);
        chk("R4 radio stays off", int'(radio_mode), 0);

        // R6 resume timing
        clr(); slp3_n = 1;
        wait_n(2); chk("R6 resume not yet", int'(ev_rs), 0);
        wait_n(1); chk("R6 resume edge 3", int'(ev_rs), 1);
        wait_n(1);
        chk("R6 radio on", int'(radio_mode), 2);
        chk("R6 deep cleared", int'(deep_sleep_ok), 0);
        chk("R6 single pulse", int'(ev_rs), 0);

        // R10 low slp0 without intent: stay working
        clr(); slp0_n = 0; wait_n(20);
        chk("R10 no idle without intent", int'(deep_sleep_ok), 0);
        // R10 with intent: enter idle
        intent = 1; wait_n(10);
        chk("R10 idle deep set", int'(deep_sleep_ok), 1);
        chk("R10 idle no events", n_st + n_rs + n_sp + n_sd, 0);
        chk("R10 radio unchanged", int'(radio_mode), 2);

        // R11 only slp3 moving does not leave idle
        slp3_n = 0; wait_n(10); slp3_n = 1; wait_n(10);
        chk("R11 stay idle", int'(deep_sleep_ok), 1);
        chk("R11 no suspend pulse", n_sp, 0);
        slp0_n = 1; wait_n(10);
        chk("R11 idle exit deep", int'(deep_sleep_ok), 0);
        chk("R11 no events", n_st + n_rs + n_sp + n_sd, 0);
        intent = 0; wait_n(4);

        // R7 suspend
        clr(); slp3_n = 0; wait_n(10);
        chk("R7 suspend pulses", n_sp, 1);
        chk("R7 radio suspended", int'(radio_mode), 1);
        chk("R7 deep set", int'(deep_sleep_ok), 1);

        // R5 slp3 high wins over slp5 low
        clr(); slp3_n = 1; slp5_n = 0; wait_n(10);
        chk("R5 resume wins", n_rs, 1);
        chk("R5 no shutdown", n_sd, 0);
        chk("R5 radio on", int'(radio_mode), 2);

        // R12 / R8 forced shutdown
        pulse_force(); wait_n(4);
        chk("R12 button pressed", int'(host_button), 1);
        clr(); slp3_n = 0; wait_n(12);
        chk("R8 shutdown pulses", n_sd, 1);
        chk("R8 suspend on the way", n_sp, 1);
        chk("R8 radio off", int'(radio_mode), 0);
        chk("R12 button released", int'(host_button), 0);
        chk("R8 rail still up", int'(rail_en), 1);

        // R5 / R9 power loss wins over slp3 high in suspend
        clr(); slp5_n = 1; wait_n(10);
        chk("R4 startup again", n_st, 1);
        clr(); s5_pgood = 0; slp3_n = 1; wait_n(10);
        chk("R5 loss beats resume", n_rs, 0);
        chk("R9 rail off from suspend", int'(rail_en), 0);

        // R9 loss from idle
        slp3_n = 0; slp5_n = 0; slp0_n = 1; intent = 0;
        s5_pgood = 1; wait_n(4);
        pulse_on(); wait_n(10);
        slp5_n = 1; wait_n(8);
        slp3_n = 1; wait_n(8);
        intent = 1; slp0_n = 0; wait_n(8);
        chk("R10 idle again", int'(deep_sleep_ok), 1);
        clr(); s5_pgood = 0; wait_n(12);
        chk("R9 rail off from idle", int'(rail_en), 0);
        chk("R9 no shutdown pulse", n_sd, 0);

        // R1 working start
        intent = 0; slp0_n = 1; slp5_n = 1; slp3_n = 1;
        s5_pgood = 1; s0_pgood = 1;
        do_reset();
        chk("R1 s0 rail", int'(rail_en), 1);
        chk("R1 s0 radio", int'(radio_mode), 2);
        chk("R1 s0 deep", int'(deep_sleep_ok), 0);
        clr(); slp3_n = 0; wait_n(10);
        chk("R1 s0 behaves as working", n_sp, 1);

        // R1 soft-off start
        slp5_n = 0; s0_pgood = 0;
        do_reset();
        chk("R1 s5 rail", int'(rail_en), 1);
        chk("R1 s5 radio", int'(radio_mode), 0);
        chk("R1 s5 deep", int'(deep_sleep_ok), 1);
        clr(); slp5_n = 1; wait_n(10);
        chk("R1 s5 behaves as soft off", n_st, 1);

        // R13 pulse width and exclusivity over the whole run
        chk("R13 overlapping or long pulses", n_multi, 0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule